// File: doc/BRIEF.md
# ADC System Calibration Sequencer

This block runs system calibration on an external sampling converter. It drives the converter's parallel control-register write port, made of an active-low chip select, an active-low write strobe and a data bus. It also watches the converter's BUSY line. The offset and gain corrections inside the converter interact with each other, so one calibration pass is not enough. For each mode the block runs the fixed number of passes needed to settle below the 12-bit level. It then reports completion, or reports an error if BUSY hangs.

Before every write, the block asks the surrounding system to apply an analog level: positive full scale for gain, or the offset level for offset. The offset level is midscale when bipolar and zero-scale when unipolar. The block waits for the system to acknowledge that the level is in place. It then counts a setup interval before ending the write, and keeps the request up until BUSY falls. The request/acknowledge pair works as a handshake:
- A request stays asserted until the converter finishes with that level.
- An acknowledge only counts when it rises while a request is up. A system can therefore apply back-pressure simply by delaying its acknowledge.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, cs_n and wr_n are high, db_oe is low, db_out is zero, and no level request, done or error is asserted.
- R2: Control word layout: bits [1:0] select the calibration (01 offset, 10 gain, 00 full system, 11 combined gain+offset); bit 2 is the trigger bit; bit 3 is the bipolar flag; all higher bits are zero. db_oe is high and db_out carries the word only while cs_n is low; otherwise db_oe is low and db_out is zero. wr_n is never low while cs_n is high.
- R3: Mode 00 (separate) runs offset (code 01, offset level) then gain (code 10, full-scale level), and repeats that pair twice: four writes.
- R4: Mode 01 (combined) runs three rounds. Each round is a write of code 11 under full-scale level, followed by code 11 with the trigger bit under the offset level. That is six writes and never more.
- R5: Mode 10 (full system) writes code 00 under full-scale level, then code 00 with the trigger bit under the offset level: two writes.
- R6: Mode 11 writes a single offset calibration (code 01) under the offset level.
- R7: At most one of lvl_fs_req and lvl_ofs_req is high. lvl_mid equals the bipolar setting captured at start whenever lvl_ofs_req is high. A request stays high until BUSY falls and drops for at least one cycle between phases.
- R8: A write starts only after a rising lvl_ack during the request. The chip select rises no sooner than SETUP_CYC cycles after that rise. cs_n stays low for exactly WR_CYC cycles.
- R9: A phase ends only when BUSY has been seen high and then low after its write.
- R10: done pulses for exactly one cycle after the final BUSY fall of the selected sequence, and the block returns to idle.
- R11: If BUSY does not complete within BUSY_TMO cycles after a write, error pulses for one cycle. The block then drops its requests, releases the bus, issues no further write and returns to idle.
- R12: start, mode_sel and bipolar are ignored while a sequence is running; mode and polarity are captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken in idle only |
| mode_sel | input | 2 | 00 separate, 01 combined, 10 full system, 11 single offset |
| bipolar | input | 1 | Input range: 1 bipolar, 0 unipolar |
| lvl_ack | input | 1 | System confirms requested analog level is applied |
| busy | input | 1 | Converter BUSY line (synchronised inside) |
| lvl_fs_req | output | 1 | Request positive full-scale input |
| lvl_ofs_req | output | 1 | Request offset reference input |
| lvl_mid | output | 1 | Offset reference is midscale (1) or zero-scale (0) |
| cs_n | output | 1 | Converter chip select, active low |
| wr_n | output | 1 | Converter write strobe, active low |
| db_out | output | DW | Control word to converter |
| db_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-cycle pulse at end of sequence |
| error | output | 1 | One-cycle pulse on BUSY timeout |

## Verification
A phase index out of step with the mode shows up at the first write after the mistake. That write carries the wrong code, trigger bit or level request, and the scoreboard compares it as soon as chip select falls. A state machine that skips the BUSY wait or the acknowledge wait shows up a few cycles later. It either writes with no pending expectation, or ends the chip select too soon after the acknowledge. A corrupted repeat count shows up at sequence end, as a missing or extra write or done pulse. A broken watchdog shows up as a missing error pulse within the timeout window, or as a bus not released after it.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SEP  = 2'b00,
    MODE_COMB = 2'b01,
    MODE_FULL = 2'b10,
    MODE_OFS  = 2'b11
  } cal_mode_e;

  localparam logic [1:0] CODE_FULL = 2'b00;
  localparam logic [1:0] CODE_OFS  = 2'b01;
  localparam logic [1:0] CODE_GAIN = 2'b10;
  localparam logic [1:0] CODE_COMB = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_SETUP, S_WRITE, S_WAIT_HI, S_WAIT_LO, S_GAP
  } seq_state_e;

  typedef struct packed {
    logic       lvl_fs;
    logic       trig;
    logic [1:0] code;
    logic       last;
  } phase_t;

endpackage

// File: rtl/cal_down_cnt.sv
module cal_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_cnt_holds_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);

endmodule

// File: rtl/cal_phase_rom.sv
module cal_phase_rom import cal_seq_pkg::*; #(
  parameter int SEP_PAIRS   = 2,
  parameter int COMB_ROUNDS = 3,
  parameter int IDXW        = 3
) (
  input  cal_mode_e       mode,
  input  logic [IDXW-1:0] idx,
  output phase_t          ph
);
  localparam logic [IDXW-1:0] SEP_LAST  = IDXW'(2*SEP_PAIRS - 1);
  localparam logic [IDXW-1:0] COMB_LAST = IDXW'(2*COMB_ROUNDS - 1);

  always_comb begin
    ph = '0;
    unique case (mode)
      MODE_SEP: begin
        ph.lvl_fs = idx[0];
        ph.code   = idx[0] ? CODE_GAIN : CODE_OFS;
        ph.trig   = 1'b0;
        ph.last   = (idx == SEP_LAST);
      end
      MODE_COMB: begin
        ph.lvl_fs = ~idx[0];
        ph.code   = CODE_COMB;
        ph.trig   = idx[0];
        ph.last   = (idx == COMB_LAST);
      end
      MODE_FULL: begin
        ph.lvl_fs = ~idx[0];
        ph.code   = CODE_FULL;
        ph.trig   = idx[0];
        ph.last   = idx[0];
      end
      MODE_OFS: begin
        ph.lvl_fs = 1'b0;
        ph.code   = CODE_OFS;
        ph.trig   = 1'b0;
        ph.last   = 1'b1;
      end
      default: ph = '0;
    endcase
  end

endmodule

// File: rtl/cal_bus_drv.sv
module cal_bus_drv #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drive,
  input  logic          bip,
  input  logic          trig,
  input  logic [1:0]    code,
  output logic          cs_n,
  output logic          wr_n,
  output logic [DW-1:0] db_out,
  output logic          db_oe
);
  localparam int PADW = DW - 4;

  logic [DW-1:0] word;
  assign word   = {{PADW{1'b0}}, bip, trig, code};
  assign cs_n   = ~drive;
  assign wr_n   = ~drive;
  assign db_oe  = drive;
  assign db_out = drive ? word : '0;

  p_wr_inside_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  p_word_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(db_out));

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top import cal_seq_pkg::*; #(
  parameter int DW          = 12,
  parameter int SETUP_CYC   = 10,
  parameter int WR_CYC      = 3,
  parameter int BUSY_TMO    = 100000,
  parameter int SEP_PAIRS   = 2,
  parameter int COMB_ROUNDS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode_sel,
  input  logic          bipolar,
  input  logic          lvl_ack,
  input  logic          busy,
  output logic          lvl_fs_req,
  output logic          lvl_ofs_req,
  output logic          lvl_mid,
  output logic          cs_n,
  output logic          wr_n,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  output logic          done,
  output logic          error
);
  localparam int MAXPH = (SEP_PAIRS > COMB_ROUNDS) ? 2*SEP_PAIRS : 2*COMB_ROUNDS;
  localparam int IDXW  = $clog2(MAXPH + 1);
  localparam int PMAX  = (SETUP_CYC > WR_CYC) ? SETUP_CYC : WR_CYC;
  localparam int PW    = $clog2(PMAX + 1);
  localparam int BW    = $clog2(BUSY_TMO + 1);

  seq_state_e      st, st_nx;
  logic [IDXW-1:0] idx;
  cal_mode_e       mode_q;
  logic            bip_q, ack_q, busy_m, busy_s;
  logic            ack_rise, active;
  logic            ph_load, ph_zero, bz_load, bz_zero;
  logic [PW-1:0]   ph_val;
  logic            done_nx, err_nx;
  phase_t          ph;

  cal_phase_rom #(.SEP_PAIRS(SEP_PAIRS), .COMB_ROUNDS(COMB_ROUNDS), .IDXW(IDXW)) u_rom (
    .mode(mode_q), .idx(idx), .ph(ph));

  cal_down_cnt #(.W(PW)) u_ph_cnt (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .val(ph_val), .zero(ph_zero));

  cal_down_cnt #(.W(BW)) u_bz_cnt (
    .clk(clk), .rst_n(rst_n), .load(bz_load), .val(BW'(BUSY_TMO - 1)), .zero(bz_zero));

  cal_bus_drv #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .drive(st == S_WRITE), .bip(bip_q), .trig(ph.trig),
    .code(ph.code), .cs_n(cs_n), .wr_n(wr_n), .db_out(db_out), .db_oe(db_oe));

  assign ack_rise = lvl_ack & ~ack_q;

  always_comb begin
    st_nx   = st;
    ph_load = 1'b0;
    ph_val  = '0;
    bz_load = 1'b0;
    done_nx = 1'b0;
    err_nx  = 1'b0;
    unique case (st)
      S_IDLE:  if (start) st_nx = S_REQ;
      S_REQ:   if (ack_rise) begin
        st_nx = S_SETUP; ph_load = 1'b1; ph_val = PW'(SETUP_CYC - 1);
      end
      S_SETUP: if (ph_zero) begin
        st_nx = S_WRITE; ph_load = 1'b1; ph_val = PW'(WR_CYC - 1);
      end
      S_WRITE: if (ph_zero) begin
        st_nx = S_WAIT_HI; bz_load = 1'b1;
      end
      S_WAIT_HI: begin
        if (busy_s)       st_nx = S_WAIT_LO;
        else if (bz_zero) begin st_nx = S_IDLE; err_nx = 1'b1; end
      end
      S_WAIT_LO: begin
        if (!busy_s) begin
          if (ph.last) begin st_nx = S_IDLE; done_nx = 1'b1; end
          else         st_nx = S_GAP;
        end else if (bz_zero) begin
          st_nx = S_IDLE; err_nx = 1'b1;
        end
      end
      S_GAP:   st_nx = S_REQ;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      mode_q <= MODE_SEP;
      bip_q  <= 1'b0;
      ack_q  <= 1'b0;
      busy_m <= 1'b0;
      busy_s <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      st     <= st_nx;
      ack_q  <= lvl_ack;
      busy_m <= busy;
      busy_s <= busy_m;
      done   <= done_nx;
      error  <= err_nx;
      if (st == S_IDLE && start) begin
        mode_q <= cal_mode_e'(mode_sel);
        bip_q  <= bipolar;
        idx    <= '0;
      end else if (st == S_WAIT_LO && !busy_s && !ph.last) begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign active      = (st == S_REQ) || (st == S_SETUP) || (st == S_WRITE) ||
                       (st == S_WAIT_HI) || (st == S_WAIT_LO);
  assign lvl_fs_req  = active & ph.lvl_fs;
  assign lvl_ofs_req = active & ~ph.lvl_fs;
  assign lvl_mid     = lvl_ofs_req & bip_q;

  p_one_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lvl_fs_req, lvl_ofs_req}));
  p_level_during_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_LO && busy_s) |-> (lvl_fs_req || lvl_ofs_req));
  p_write_has_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (lvl_fs_req || lvl_ofs_req));
  p_next_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP) |-> $past(!busy_s));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_err_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (cs_n && !db_oe && !lvl_fs_req && !lvl_ofs_req));

endmodule

// File: tb/sim_cal_seq_top.sv
module sim_cal_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 12;
  localparam int SETUP      = 4;
  localparam int WRC        = 2;
  localparam int TMO        = 40;
  localparam int BUSY_LEN   = 10;
  localparam int WDOG       = 150000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bipolar = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic lvl_ack = 1'b0, busy = 1'b0;
  logic lvl_fs_req, lvl_ofs_req, lvl_mid, cs_n, wr_n, db_oe, done, error;
  logic [DW-1:0] db_out;

  cal_seq_top #(.DW(DW), .SETUP_CYC(SETUP), .WR_CYC(WRC), .BUSY_TMO(TMO),
                .SEP_PAIRS(2), .COMB_ROUNDS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel), .bipolar(bipolar),
    .lvl_ack(lvl_ack), .busy(busy), .lvl_fs_req(lvl_fs_req), .lvl_ofs_req(lvl_ofs_req),
    .lvl_mid(lvl_mid), .cs_n(cs_n), .wr_n(wr_n), .db_out(db_out), .db_oe(db_oe),
    .done(done), .error(error));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [13:0] expq[$];          // {fs, mid, word}
  int  done_cnt = 0, err_cnt = 0, writes = 0;
  bit  done_wide = 0, rel_bad = 0, hold_bad = 0, stuck = 0;
  bit  cs_prev = 1, ack_prev = 0, done_prev = 0;
  int  ack_cyc = 0, cs_fall_cyc = 0, bcnt = 0;
  logic [2:0] ack_sh = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor + converter and level models, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      chk(0, "WDOG", "run did not finish", cyc, WDOG);
      summary();
    end
    if (rst_n) begin
      if (lvl_ack && !ack_prev) ack_cyc = cyc;
      if (cs_n && (db_oe || db_out != '0 || !wr_n)) rel_bad = 1;
      if (busy && !stuck && !(lvl_fs_req || lvl_ofs_req)) hold_bad = 1;
      if (done) begin
        done_cnt++;
        if (done_prev) done_wide = 1;
      end
      if (error) err_cnt++;
      if (!cs_n && cs_prev) begin
        writes++;
        cs_fall_cyc = cyc;
        chk(!rel_bad, "R2", "bus not released outside write", rel_bad, 0);
        rel_bad = 0;
        chk(db_oe && !wr_n, "R2", "bus driven in write", {db_oe, wr_n}, 2'b10);
        if (expq.size() == 0) chk(0, "R4", "write with no expected item", db_out, 0);
        else begin
          logic [13:0] e;
          e = expq.pop_front();
          chk({lvl_fs_req, lvl_mid, db_out} == e, "R3", "write word/level",
              {lvl_fs_req, lvl_mid, db_out}, e);
          chk(lvl_ofs_req == !e[13], "R7", "offset request", lvl_ofs_req, !e[13]);
        end
      end
      if (cs_n && !cs_prev) begin
        chk(cyc - ack_cyc >= SETUP, "R8", "setup from ack", cyc - ack_cyc, SETUP);
        chk(cyc - cs_fall_cyc == WRC, "R8", "write width", cyc - cs_fall_cyc, WRC);
        bcnt = BUSY_LEN + 2;
      end
    end
    cs_prev   = cs_n;
    ack_prev  = lvl_ack;
    done_prev = done;
    // models drive after sampling
    ack_sh  = {ack_sh[1:0], lvl_fs_req | lvl_ofs_req};
    lvl_ack = ack_sh[2];
    if (bcnt != 0) bcnt--;
    busy = stuck || (bcnt != 0 && bcnt <= BUSY_LEN);
  end

  function automatic logic [13:0] item(input bit fs, input bit bip,
                                       input logic [1:0] code, input bit trig);
    return {fs, (!fs && bip), 8'h00, bip, trig, code};
  endfunction

  task automatic push_mode(input logic [1:0] m, input bit bip);
    case (m)
      2'b00: for (int p = 0; p < 2; p++) begin
               expq.push_back(item(0, bip, 2'b01, 0));
               expq.push_back(item(1, bip, 2'b10, 0));
             end
      2'b01: for (int r = 0; r < 3; r++) begin
               expq.push_back(item(1, bip, 2'b11, 0));
               expq.push_back(item(0, bip, 2'b11, 1));
             end
      2'b10: begin
               expq.push_back(item(1, bip, 2'b00, 0));
               expq.push_back(item(0, bip, 2'b00, 1));
             end
      default: expq.push_back(item(0, bip, 2'b01, 0));
    endcase
  endtask

  task automatic run(input logic [1:0] m, input bit bip, input bit poke,
                     input string req, input int nwr);
    done_cnt = 0; err_cnt = 0; writes = 0; done_wide = 0; hold_bad = 0;
    push_mode(m, bip);
    @(negedge clk); start = 1; mode_sel = m; bipolar = bip;
    @(negedge clk); start = 0; mode_sel = ~m; bipolar = ~bip;
    if (poke) begin  // R12: start while running must be ignored
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 4000 && done_cnt == 0 && err_cnt == 0; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(done_cnt == 1 && err_cnt == 0, "R10", {req, " one done"}, done_cnt, 1);
    chk(!done_wide, "R10", "done single cycle", done_wide, 0);
    chk(writes == nwr && expq.size() == 0, req, "write count", writes, nwr);
    chk(!hold_bad, "R7", "level held while busy", hold_bad, 0);
    chk(cs_n && !db_oe && !lvl_fs_req && !lvl_ofs_req, "R10", "idle after done",
        {cs_n, db_oe, lvl_fs_req, lvl_ofs_req}, 4'b1000);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && !db_oe && db_out == '0 && !lvl_fs_req && !lvl_ofs_req
        && !done && !error, "R1", "reset state",
        {cs_n, wr_n, db_oe, lvl_fs_req, lvl_ofs_req, done, error}, 7'b1100000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run(2'b00, 0, 0, "R3", 4);
    run(2'b01, 1, 0, "R4", 6);
    run(2'b10, 0, 0, "R5", 2);
    run(2'b11, 1, 0, "R6", 1);
    run(2'b11, 0, 0, "R6", 1);
    run(2'b10, 1, 1, "R12", 2);
    run(2'b00, 1, 1, "R12", 4);
    // R11: BUSY never falls during the first phase of a full calibration
    done_cnt = 0; err_cnt = 0; writes = 0;
    stuck = 1;
    expq.push_back(item(1, 0, 2'b00, 0));
    @(negedge clk); start = 1; mode_sel = 2'b10; bipolar = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < 400 && err_cnt == 0; i++) @(negedge clk);
    chk(err_cnt == 1 && done_cnt == 0, "R11", "error pulse on timeout", err_cnt, 1);
    chk(cs_n && !db_oe && !lvl_fs_req && !lvl_ofs_req, "R11", "released after error",
        {cs_n, db_oe, lvl_fs_req, lvl_ofs_req}, 4'b1000);
    repeat (40) @(negedge clk);
    chk(writes == 1 && err_cnt == 1, "R11", "no write after error", writes, 1);
    stuck = 0;
    repeat (10) @(negedge clk);
    expq.delete();
    run(2'b11, 0, 0, "R9", 1);
    summary();
  end

endmodule